// File: doc/BRIEF.md
# SD Host Command and Status Register File

This block is the byte-addressed register file that sits between a processor bus and the command engine of an SD/MMC host. Software uses it to program the command index, a 32-bit argument, the response type, the data block size and block count, the bus width and card power controls, a data timeout value and two interrupt enable bytes. Writing the control byte sets the command type and direction, and can fire a start pulse and a response-FIFO reset pulse toward the command engine.

Four status bytes collect hardware events. An event input sets status bits. Software clears a bit by writing 1 to it. A single level interrupt is raised while any enabled status source is pending, and only when the master interrupt enable in the block-length halfword is set. Writing the soft-reset bit in the bus-mode byte returns the whole file to its reset state.

Top module: `sdh_csr`

## Requirements
- R1: After reset every register reads 0x00, and `irq`, `cmd_start`, `fifo_reset`, `cmd_write` and `cmd_type` are all 0.
- R2: Configuration bytes are read/write at these byte offsets: command index 0x01, response type 0x02, argument 0x04..0x07 (0x04 holds bits 7:0), bus mode 0x08 (bit 1 four-bit, bit 2 eight-bit, bit 4 card power off), block length 0x0C/0x0D (low byte first; bits 10:0 size minus one, bit 15 interrupt enable), block count 0x0E/0x0F, mask 0 at 0x24, mask 1 at 0x25, data timeout 0x3C/0x3D.
- R3: A write to the control byte (0x00) with bit 0 set drives `cmd_start` high for exactly the cycle after the write; with bit 3 set it drives `fifo_reset` the same way. Both bits read back 0 once the pulse has passed.
- R4: Control byte bits 7:4 hold the command type (0 none, 1 single write, 2 single read, 3 multi write, 4 multi read, 7 stop) and bit 2 the write direction; both are held, read back and drive `cmd_type` and `cmd_write`.
- R5: A 1 on bit 8n+k of `evt_set` sets bit k of status byte n (offset 0x28+n) at the next clock edge, and the bit stays set until it is cleared.
- R6: Writing a status byte clears exactly the bits written as 1; bits written as 0 are unchanged.
- R7: When an event sets a status bit in the same cycle that a write clears it, the bit ends set.
- R8: `irq` is high when block-length bit 15 is set and any status-0 bit 7:4 or status-1 bit 7:1 is set together with the same bit of its mask byte; mask-0 bits 3:0 and mask-1 bit 0 never raise it.
- R9: Status bits are captured while block-length bit 15 is clear, and `irq` is then held low.
- R10: Writing the bus-mode byte with bit 7 set returns every register to its reset value at that edge; bit 7 always reads 0.
- R11: Offsets not listed in R2, R4 and R5 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte address |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| evt_set | input | 32 | Hardware set events, byte n for status byte n |
| cmd_start | output | 1 | One-cycle command start pulse |
| fifo_reset | output | 1 | One-cycle response FIFO reset pulse |
| cmd_type | output | 4 | Command type from control bits 7:4 |
| cmd_write | output | 1 | Write direction from control bit 2 |
| irq | output | 1 | Level interrupt |

## Verification
A stuck or lost status bit shows on the next read of its status byte and, when its mask and the enable are set, on `irq` in the same cycle, since the interrupt is a direct function of registered state. A start or FIFO-reset bit that fails to self-clear shows as a pulse longer than one cycle and as a 1 read back from the control byte one cycle after the write. A wrong clear/set priority or a decode slip surfaces on the read of the affected byte right after the offending edge, so every fault is visible within one to two cycles of its cause.

// File: rtl/sdh_csr_pkg.sv
package sdh_csr_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned NBYTES = 1 << ADDR_W;
  localparam int unsigned NSTS   = 4;

  localparam logic [ADDR_W-1:0] A_CTL     = 6'h00;
  localparam logic [ADDR_W-1:0] A_BUSMODE = 6'h08;
  localparam logic [ADDR_W-1:0] A_BLKLEN  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_MASK0   = 6'h24;
  localparam logic [ADDR_W-1:0] A_MASK1   = 6'h25;
  localparam logic [ADDR_W-1:0] A_STS     = 6'h28;

  // Which byte offsets hold plain read/write configuration storage.
  function automatic bit cfg_writable(input int unsigned a);
    case (a)
      'h01, 'h02, 'h04, 'h05, 'h06, 'h07, 'h08,
      'h0C, 'h0D, 'h0E, 'h0F, 'h24, 'h25, 'h3C, 'h3D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Bits that may be stored at a configuration offset.
  function automatic logic [7:0] cfg_keep(input int unsigned a);
    return (a == 'h08) ? 8'h7F : 8'hFF;
  endfunction

  // Next state of a write-1-to-clear byte; set events win over clears.
  function automatic logic [7:0] w1c_next(input logic [7:0] cur,
                                          input logic [7:0] clr,
                                          input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Level interrupt from status, masks and master enable.
  function automatic logic irq_eval(input logic [7:0] s0, input logic [7:0] m0,
                                    input logic [7:0] s1, input logic [7:0] m1,
                                    input logic en);
    return en & ((|(s0 & m0 & 8'hF0)) | (|(s1 & m1 & 8'hFE)));
  endfunction
endpackage

// File: rtl/sdh_cfg_bytes.sv
module sdh_cfg_bytes
  import sdh_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [8*NBYTES-1:0] cfg_flat
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    if (cfg_writable(i)) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= 8'h00;
        else if (srst)                     q <= 8'h00;
        else if (wr && addr == ADDR_W'(i)) q <= wdata & cfg_keep(i);
      end
      assign cfg_flat[8*i +: 8] = q;
    end else begin : g_none
      assign cfg_flat[8*i +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/sdh_ctl_byte.sv
module sdh_ctl_byte
  import sdh_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       wr_ctl,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_rd,
  output logic       cmd_start,
  output logic       fifo_reset,
  output logic [3:0] cmd_type,
  output logic       cmd_write
);
  logic start_req, flush_req;
  assign start_req = wr_ctl & wdata[0] & ~srst;
  assign flush_req = wr_ctl & wdata[3] & ~srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_start <= 1'b0; fifo_reset <= 1'b0; cmd_type <= 4'h0; cmd_write <= 1'b0;
    end else if (srst) begin
      cmd_start <= 1'b0; fifo_reset <= 1'b0; cmd_type <= 4'h0; cmd_write <= 1'b0;
    end else begin
      cmd_start  <= start_req;
      fifo_reset <= flush_req;
      if (wr_ctl) begin
        cmd_type  <= wdata[7:4];
        cmd_write <= wdata[2];
      end
    end
  end

  assign ctl_rd = {cmd_type, fifo_reset, cmd_write, 1'b0, cmd_start};

  // R3: a start request produces the pulse, and every pulse has a request
  a_r3_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> cmd_start);
  a_r3_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(start_req));
  a_r3_flush_origin: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |-> $past(flush_req));
  // R4: the type field only moves on a control write or soft reset
  a_r4_type_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctl && !srst) |=> $stable(cmd_type));
endmodule

// File: rtl/sdh_sts_byte.sv
module sdh_sts_byte
  import sdh_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic [7:0] set_i,
  input  logic [7:0] clr_i,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 8'h00;
    else if (srst) q <= 8'h00;
    else           q <= w1c_next(q, clr_i, set_i);
  end

  // R5: a bit only rises when an event asks for it
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(q) & ~$past(set_i)) == 8'h00));
  // R6: cleared bits without a concurrent event go low
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> ((q & $past(clr_i & ~set_i)) == 8'h00));
  // R7: an event always lands, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> ((q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/sdh_csr.sv
module sdh_csr
  import sdh_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [31:0] evt_set,
  output logic        cmd_start,
  output logic        fifo_reset,
  output logic [3:0]  cmd_type,
  output logic        cmd_write,
  output logic        irq
);
  logic              soft_rst;
  logic [8*NBYTES-1:0] cfg_flat;
  logic [7:0]        ctl_rd;
  logic [7:0]        sts [NSTS];
  logic              blk_irq_en;

  assign soft_rst = reg_wr && reg_addr == A_BUSMODE && reg_wdata[7];

  sdh_cfg_bytes u_cfg (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst),
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .cfg_flat(cfg_flat)
  );

  sdh_ctl_byte u_ctl (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst),
    .wr_ctl(reg_wr && reg_addr == A_CTL), .wdata(reg_wdata), .ctl_rd(ctl_rd),
    .cmd_start(cmd_start), .fifo_reset(fifo_reset),
    .cmd_type(cmd_type), .cmd_write(cmd_write)
  );

  for (genvar n = 0; n < NSTS; n++) begin : g_sts
    logic [7:0] clr;
    assign clr = (reg_wr && reg_addr == A_STS + ADDR_W'(n)) ? reg_wdata : 8'h00;
    sdh_sts_byte u_sts (
      .clk(clk), .rst_n(rst_n), .srst(soft_rst),
      .set_i(evt_set[8*n +: 8]), .clr_i(clr), .q(sts[n])
    );
  end

  assign blk_irq_en = cfg_flat[8*(A_BLKLEN+1) + 7];
  assign irq = irq_eval(sts[0], cfg_flat[8*A_MASK0 +: 8],
                        sts[1], cfg_flat[8*A_MASK1 +: 8], blk_irq_en);

  always_comb begin
    if (reg_addr == A_CTL)
      reg_rdata = ctl_rd;
    else if (reg_addr >= A_STS && reg_addr < A_STS + ADDR_W'(NSTS))
      reg_rdata = sts[reg_addr[1:0]];
    else
      reg_rdata = cfg_flat[8*reg_addr +: 8];
  end

  // R9: no interrupt while the master enable is clear
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_irq_en |-> !irq);
  // R10: soft reset leaves the file idle on the next cycle
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq && !cmd_start && !fifo_reset && cmd_type == 4'h0));
endmodule

// File: tb/sdh_csr_test.sv
module sdh_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] evt_set = '0;
  logic        cmd_start, fifo_reset, cmd_write, irq;
  logic [3:0]  cmd_type;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdh_csr uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    reg_addr = a; #1; chk(req, reg_rdata, exp);
  endtask

  task automatic ev(input logic [31:0] s);
    @(negedge clk); evt_set = s;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 64; a++) rd("R1", 6'(a), 8'h00);
    chk("R1 outputs", {irq, cmd_start, fifo_reset, cmd_write, cmd_type}, 0);
  endtask

  task automatic t_storage;
    wr(6'h01, 8'h11); wr(6'h02, 8'h09);
    wr(6'h04, 8'h78); wr(6'h05, 8'h56); wr(6'h06, 8'h34); wr(6'h07, 8'h12);
    wr(6'h08, 8'h16); wr(6'h0C, 8'hFF); wr(6'h0D, 8'h01); wr(6'h0E, 8'h08);
    wr(6'h3C, 8'hFF); wr(6'h3D, 8'h1F);
    rd("R2 index", 6'h01, 8'h11); rd("R2 rsp", 6'h02, 8'h09);
    rd("R2 arg0", 6'h04, 8'h78); rd("R2 arg3", 6'h07, 8'h12);
    rd("R2 busmode", 6'h08, 8'h16); rd("R2 blklen", 6'h0D, 8'h01);
    rd("R2 blkcnt", 6'h0E, 8'h08); rd("R2 timeout", 6'h3D, 8'h1F);
    rd("R11 gap", 6'h03, 8'h00); rd("R11 gap", 6'h30, 8'h00);
  endtask

  task automatic t_control;
    wr(6'h00, 8'h35);             // type 3, write, start
    chk("R3 start pulse", cmd_start, 1'b1);
    chk("R3 no flush", fifo_reset, 1'b0);
    chk("R4 type", cmd_type, 4'h3);
    chk("R4 write", cmd_write, 1'b1);
    @(negedge clk);
    chk("R3 start cleared", cmd_start, 1'b0);
    rd("R3 R4 readback", 6'h00, 8'h34);
    wr(6'h00, 8'h48);             // type 4, read, flush
    chk("R3 flush pulse", fifo_reset, 1'b1);
    chk("R3 no start", cmd_start, 1'b0);
    @(negedge clk);
    chk("R3 flush cleared", fifo_reset, 1'b0);
    rd("R4 readback", 6'h00, 8'h40);
    wr(6'h00, 8'h70);
    chk("R4 stop type", cmd_type, 4'h7);
  endtask

  task automatic t_status;
    ev(32'h0000_8612);            // sts0=0x12, sts1=0x86
    rd("R5 sts0", 6'h28, 8'h12); rd("R5 sts1", 6'h29, 8'h86);
    repeat (3) @(negedge clk);
    rd("R5 held", 6'h29, 8'h86);
    ev(32'hA500_0000);
    rd("R5 sts3", 6'h2B, 8'hA5);
    wr(6'h29, 8'h04);
    rd("R6 partial clear", 6'h29, 8'h82);
    wr(6'h2B, 8'hFF);
    rd("R6 full clear", 6'h2B, 8'h00);
    // same-cycle clear and set of sts1 bit 1
    @(negedge clk); reg_addr = 6'h29; reg_wdata = 8'h82; reg_wr = 1'b1; evt_set = 32'h0000_0200;
    @(negedge clk); reg_wr = 1'b0; evt_set = '0;
    rd("R7 set wins", 6'h29, 8'h02);
  endtask

  task automatic t_irq;
    wr(6'h28, 8'hFF); wr(6'h29, 8'hFF);
    wr(6'h0D, 8'h00);
    ev(32'h0000_0210);            // sts0 bit4, sts1 bit1
    wr(6'h24, 8'h10); wr(6'h25, 8'h02);
    chk("R9 gated", irq, 1'b0);
    rd("R9 captured", 6'h29, 8'h02);
    wr(6'h0D, 8'h80);
    chk("R8 irq on", irq, 1'b1);
    wr(6'h28, 8'h10);
    chk("R8 still sts1", irq, 1'b1);
    wr(6'h29, 8'h02);
    chk("R8 irq off", irq, 1'b0);
    wr(6'h24, 8'h0F); wr(6'h25, 8'h01);
    ev(32'h0000_010F);
    chk("R8 masked low bits", irq, 1'b0);
    wr(6'h25, 8'h80);
    ev(32'h0000_8000);
    chk("R8 wcrc source", irq, 1'b1);
  endtask

  task automatic t_soft;
    wr(6'h00, 8'h20);
    wr(6'h08, 8'h82);
    rd("R10 index", 6'h01, 8'h00); rd("R10 busmode", 6'h08, 8'h00);
    rd("R10 sts1", 6'h29, 8'h00); rd("R10 mask1", 6'h25, 8'h00);
    rd("R10 blklen", 6'h0D, 8'h00);
    chk("R10 outputs", {irq, cmd_type}, 0);
    wr(6'h08, 8'h02);
    rd("R10 bit7 zero", 6'h08, 8'h02);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_storage; t_control; t_status; t_irq; t_soft;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule